// File: doc/BRIEF.md
# Timed Overload Bias-Cutoff Monitor

This block guards a photodetector array against sustained overload. Every accepted beat of the sample stream carries one sample per channel. Each enabled channel is compared against a single shared threshold, and a polarity bit selects the direction. A violation counts only if it is seen across enough consecutive tick intervals. The tick is a one-cycle pulse, nominally every 10 µs. Once the programmed count of intervals is exceeded, the detector bias enable is dropped and a sticky overload flag is raised. The flag drives an indicator LED, and only a write to the status-clear address resets it.

Turning the bias on takes two steps. First, a fixed arming code must be written. Only then does a bias-on command take effect. A wrong code disarms the block. Clearing the overload also disarms it. While the flag is set, bias-on commands are refused.

The sample input is a valid/ready stream. `s_ready` is low during reset and high from the first clock edge after reset onwards, so the monitor never applies back-pressure. A beat is consumed on every cycle in which `s_valid` and `s_ready` are both high. `s_data` has no meaning while `s_valid` is low.

Top module: `bias_overload_guard`

## Requirements
- R1: After reset, `bias_en`, `ovl_flag` and `ovl_led` are 0.
- R2: With the polarity bit (config bit SW, 14 by default) at 0, a channel is beyond when its sample is strictly greater than the level in config bits SW-1..0. A sample equal to the level is not beyond.
- R3: With the polarity bit at 1, a channel is beyond when its sample is strictly less than the level. A sample equal to the level is not beyond.
- R4: Channel i takes part only when bit i of the channel mask (address 5, reset value all ones) is 1. No channel takes part while the detection enable (config bit SW+1) is 0. Config word is address 0.
- R5: A tick interval counts as violating if it contains a beat in which a participating channel is beyond. The interval count increments at the tick. An interval without such a beat returns the count to 0. A violating beat trips the monitor when the count is at least the time limit (address 1, TW bits).
- R6: With a time limit of 0, the first violating beat trips. A trip sets `ovl_flag` and clears `bias_en` at the clock edge that accepts the beat.
- R7: Any write to address 2, whatever its data, clears `ovl_flag`, the armed state and the interval count. The flag never clears otherwise.
- R8: A write to address 4 with data bit 0 set turns `bias_en` on only if the arming code (ARM_CODE, default 0xB1A5) was the last value written to address 3. A write to address 4 with bit 0 clear turns the bias off.
- R9: Writing any value other than ARM_CODE to address 3 disarms, so a following bias-on command is ignored.
- R10: While `ovl_flag` is set, bias-on is refused. After a clear, the block must be re-armed before bias can come on again.
- R11: `ovl_led` is lit exactly while `ovl_flag` is set.
- R12: `s_ready` is held high after reset. Data presented with `s_valid` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle interval pulse (10 µs) |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat ready |
| s_data | input | NCH*SW | Channel samples, channel i at bits i*SW+SW-1..i*SW |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | DW | Configuration write data |
| bias_en | output | 1 | Detector bias enable |
| ovl_flag | output | 1 | Latched overload status |
| ovl_led | output | 1 | Overload indicator drive |

## Verification
The bound checker watches several rules on every cycle:
- the bias is never on while the flag is set;
- the bias only rises right after a bias command write;
- the flag only rises right after an accepted beat, and only falls right after a status-clear write;
- ready stays high once raised.

Other behaviour can only be shown by the bench's scenarios:
- the threshold direction, including equality;
- masking and the global enable;
- the interval-count window and its reset by a clean interval;
- rejection of wrong codes;
- the need to re-arm after a clear.

// File: rtl/ovg_pkg.sv
package ovg_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 3'd0,
    A_TIME = 3'd1,
    A_CLR  = 3'd2,
    A_ARM  = 3'd3,
    A_BIAS = 3'd4,
    A_MASK = 3'd5
  } ovg_addr_e;

  typedef struct packed {
    logic enable;
    logic below;
  } ovl_mode_t;

endpackage

// File: rtl/ovg_level_cmp.sv
module ovg_level_cmp
  import ovg_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SW  = 14
) (
  input  logic [NCH*SW-1:0] samples,
  input  logic [SW-1:0]     level,
  input  ovl_mode_t         mode,
  input  logic [NCH-1:0]    mask,
  output logic              beyond_any
);

  logic [NCH-1:0] beyond;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SW-1:0] smp;
    assign smp = samples[i*SW +: SW];
    always_comb begin
      if (mode.below) beyond[i] = mask[i] && (smp < level);
      else            beyond[i] = mask[i] && (smp > level);
    end
  end

  assign beyond_any = mode.enable && (|beyond);

endmodule

// File: rtl/ovg_duration.sv
module ovg_duration #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_en,
  input  logic          viol,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  input  logic          clr,
  output logic          trip
);

  logic [TW-1:0] cnt;
  logic          hit;
  logic          seen;

  assign seen = hit || viol;
  assign trip = viol && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !det_en) begin
      cnt <= '0;
      hit <= 1'b0;
    end else if (tick) begin
      hit <= 1'b0;
      if (seen) cnt <= (cnt != '1) ? cnt + 1'b1 : cnt;
      else      cnt <= '0;
    end else if (viol) begin
      hit <= 1'b1;
    end
  end

endmodule

// File: rtl/ovg_bias_ctrl.sv
module ovg_bias_ctrl #(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] ARM_CODE = 16'hB1A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_we,
  input  logic [DW-1:0] arm_data,
  input  logic          cmd_we,
  input  logic          cmd_on,
  input  logic          clr,
  input  logic          trip,
  output logic          bias_en,
  output logic          ovl_flag
);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      bias_en  <= 1'b0;
      ovl_flag <= 1'b0;
    end else begin
      if (clr)         armed <= 1'b0;
      else if (arm_we) armed <= (arm_data == ARM_CODE);

      if (trip)     ovl_flag <= 1'b1;
      else if (clr) ovl_flag <= 1'b0;

      if (trip)        bias_en <= 1'b0;
      else if (cmd_we) bias_en <= cmd_on && armed && !ovl_flag;
    end
  end

endmodule

// File: rtl/bias_overload_guard.sv
module bias_overload_guard
  import ovg_pkg::*;
#(
  parameter int            NCH      = 4,
  parameter int            SW       = 14,
  parameter int            TW       = 16,
  parameter int            DW       = 16,
  parameter logic [DW-1:0] ARM_CODE = 16'hB1A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [NCH*SW-1:0] s_data,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic              bias_en,
  output logic              ovl_flag,
  output logic              ovl_led
);

  localparam int POL_BIT = SW;
  localparam int EN_BIT  = SW + 1;

  ovg_addr_e      addr;
  logic [SW-1:0]  level_q;
  ovl_mode_t      mode_q;
  logic [TW-1:0]  limit_q;
  logic [NCH-1:0] mask_q;
  logic           ready_q;
  logic           beat;
  logic           beyond_any;
  logic           viol;
  logic           trip;
  logic           clr;

  assign addr    = ovg_addr_e'(cfg_addr);
  assign clr     = cfg_we && (addr == A_CLR);
  assign s_ready = ready_q;
  assign beat    = s_valid && ready_q;
  assign viol    = beat && beyond_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      level_q <= '0;
      mode_q  <= '0;
      limit_q <= '0;
      mask_q  <= '1;
    end else begin
      ready_q <= 1'b1;
      if (cfg_we) begin
        unique case (addr)
          A_CFG: begin
            level_q       <= cfg_wdata[SW-1:0];
            mode_q.below  <= cfg_wdata[POL_BIT];
            mode_q.enable <= cfg_wdata[EN_BIT];
          end
          A_TIME:  limit_q <= cfg_wdata[TW-1:0];
          A_MASK:  mask_q  <= cfg_wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  ovg_level_cmp #(.NCH(NCH), .SW(SW)) u_cmp (
    .samples    (s_data),
    .level      (level_q),
    .mode       (mode_q),
    .mask       (mask_q),
    .beyond_any (beyond_any)
  );

  ovg_duration #(.TW(TW)) u_dur (
    .clk    (clk),
    .rst_n  (rst_n),
    .det_en (mode_q.enable),
    .viol   (viol),
    .tick   (tick),
    .limit  (limit_q),
    .clr    (clr),
    .trip   (trip)
  );

  ovg_bias_ctrl #(.DW(DW), .ARM_CODE(ARM_CODE)) u_bias (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_we   (cfg_we && (addr == A_ARM)),
    .arm_data (cfg_wdata),
    .cmd_we   (cfg_we && (addr == A_BIAS)),
    .cmd_on   (cfg_wdata[0]),
    .clr      (clr),
    .trip     (trip),
    .bias_en  (bias_en),
    .ovl_flag (ovl_flag)
  );

  assign ovl_led = ovl_flag;

endmodule

// File: rtl/ovg_checker.sv
module ovg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic       bias_en,
  input logic       ovl_flag
);

  // R10: bias never on while the overload flag is latched
  p_no_bias_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_flag |-> !bias_en);

  // R8: bias only rises after a bias command write
  p_bias_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_en) |-> ($past(cfg_we) && ($past(cfg_addr) == 3'd4)));

  // R7: flag falls only after a status-clear write
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl_flag) |-> ($past(cfg_we) && ($past(cfg_addr) == 3'd2)));

  // R5: a trip needs an accepted beat in the previous cycle
  p_trip_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_flag) |-> ($past(s_valid) && $past(s_ready)));

  // R12: ready stays high once raised
  p_ready_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready);

endmodule

bind bias_overload_guard ovg_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .bias_en  (bias_en),
  .ovl_flag (ovl_flag)
);

// File: tb/sim_bias_overload_guard.sv
module sim_bias_overload_guard;

  localparam int NCH = 4;
  localparam int SW  = 14;
  localparam int DW  = 16;
  localparam logic [DW-1:0] CODE = 16'hB1A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [NCH*SW-1:0] s_data = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic bias_en, ovl_flag, ovl_led;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  bias_overload_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bias_en(bias_en), .ovl_flag(ovl_flag), .ovl_led(ovl_led)
  );

  typedef struct packed {
    logic              below;
    logic              en;
    logic [NCH-1:0]    mask;
    logic [SW-1:0]     lvl;
    logic [NCH*SW-1:0] smp;
    logic              exp_trip;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b1, 4'hF, 14'd1000, {14'd500,  14'd500,  14'd500,  14'd500},  1'b0}, // R2
    '{1'b0, 1'b1, 4'hF, 14'd1000, {14'd500,  14'd1001, 14'd500,  14'd500},  1'b1}, // R2
    '{1'b0, 1'b1, 4'hF, 14'd1000, {14'd500,  14'd500,  14'd500,  14'd1000}, 1'b0}, // R2 equal
    '{1'b1, 1'b1, 4'hF, 14'd1000, {14'd1500, 14'd1500, 14'd1500, 14'd1500}, 1'b0}, // R3
    '{1'b1, 1'b1, 4'hF, 14'd1000, {14'd1500, 14'd1500, 14'd999,  14'd1500}, 1'b1}, // R3
    '{1'b1, 1'b1, 4'hF, 14'd1000, {14'd1000, 14'd1000, 14'd1000, 14'd1000}, 1'b0}, // R3 equal
    '{1'b0, 1'b1, 4'hB, 14'd1000, {14'd500,  14'd5000, 14'd500,  14'd500},  1'b0}, // R4 mask
    '{1'b0, 1'b0, 4'hF, 14'd1000, {14'd16383,14'd16383,14'd16383,14'd16383},1'b0}, // R4 off
    '{1'b0, 1'b1, 4'h1, 14'd1000, {14'd500,  14'd500,  14'd500,  14'd16383},1'b1}  // R4 mask
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic beat(input logic [NCH*SW-1:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  localparam logic [NCH*SW-1:0] HOT  = {14'd500, 14'd500, 14'd500, 14'd3000};
  localparam logic [NCH*SW-1:0] COLD = {14'd500, 14'd500, 14'd500, 14'd500};

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bias", bias_en, 1'b0);
    chk("R1 flag", ovl_flag, 1'b0);
    chk("R1 led", ovl_led, 1'b0);
    chk("R12 ready", s_ready, 1'b1);

    // table walk: detection direction, masking, enable (time limit 0)
    wr(3'd1, 16'd0);
    foreach (VECS[i]) begin
      wr(3'd0, {VECS[i].en, VECS[i].below, VECS[i].lvl});
      wr(3'd5, {{(DW-NCH){1'b0}}, VECS[i].mask});
      beat(VECS[i].smp);
      chk($sformatf("R2/R3/R4 vec%0d", i), ovl_flag, VECS[i].exp_trip);
      wr(3'd2, 16'h0000);
      chk($sformatf("R7 clr vec%0d", i), ovl_flag, 1'b0);
    end
    wr(3'd5, 16'h000F);
    wr(3'd0, {2'b10, 14'd1000});

    // R12: data without valid is ignored
    @(negedge clk);
    s_data = HOT;
    @(negedge clk);
    @(negedge clk);
    chk("R12 no valid", ovl_flag, 1'b0);

    // R8: bias requires arming
    wr(3'd4, 16'h0001);
    chk("R8 unarmed", bias_en, 1'b0);
    wr(3'd3, CODE);
    wr(3'd4, 16'h0001);
    chk("R8 armed on", bias_en, 1'b1);
    wr(3'd4, 16'h0000);
    chk("R8 off", bias_en, 1'b0);

    // R9: wrong code disarms
    wr(3'd3, CODE ^ 16'h0100);
    wr(3'd4, 16'h0001);
    chk("R9 wrong code", bias_en, 1'b0);

    // R5: duration window of 3 intervals
    wr(3'd1, 16'd3);
    wr(3'd3, CODE);
    wr(3'd4, 16'h0001);
    chk("R8 on again", bias_en, 1'b1);
    for (int k = 0; k < 3; k++) begin
      beat(HOT);
      tk();
    end
    chk("R5 not yet", ovl_flag, 1'b0);
    chk("R5 bias held", bias_en, 1'b1);
    beat(HOT);
    chk("R5 trip", ovl_flag, 1'b1);
    chk("R6 bias cut", bias_en, 1'b0);
    chk("R11 led on", ovl_led, 1'b1);

    // R10: refused while flagged
    wr(3'd3, CODE);
    wr(3'd4, 16'h0001);
    chk("R10 refused", bias_en, 1'b0);
    wr(3'd2, 16'hFFFF);
    chk("R7 clear", ovl_flag, 1'b0);
    chk("R11 led off", ovl_led, 1'b0);
    wr(3'd4, 16'h0001);
    chk("R10 rearm needed", bias_en, 1'b0);

    // R5: clean interval resets the count
    beat(HOT); tk();
    beat(HOT); tk();
    tk();
    beat(HOT); tk();
    beat(HOT);
    chk("R5 clean reset", ovl_flag, 1'b0);
    beat(HOT); tk();
    beat(HOT); tk();
    beat(HOT);
    chk("R5 trip after rebuild", ovl_flag, 1'b1);
    wr(3'd2, 16'h0000);

    // R6: immediate trip with limit 0
    wr(3'd1, 16'd0);
    wr(3'd3, CODE);
    wr(3'd4, 16'h0001);
    chk("R10 rearmed on", bias_en, 1'b1);
    beat(COLD);
    chk("R6 cold", ovl_flag, 1'b0);
    beat(HOT);
    chk("R6 trip", ovl_flag, 1'b1);
    chk("R6 bias off", bias_en, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule